// File: doc/BRIEF.md
# In-System Flash Programming Controller

This block lets a CPU rewrite the on-chip program store without outside equipment. The CPU writes five byte-wide registers: a control register holding the master enable, a target address split into high and low bytes, a data byte, and a command register. Setting the command's START bit launches one of four operations: byte program, 512-byte page erase, chip erase or chip protect. A busy output stays high while the operation's fixed latency counts down. When the count ends, the operation is applied to a byte array built from synthesizable registers.

A separate registered read port serves instruction fetch and data reads, with one cycle of latency. Once protect is set, this port returns 0x00. A reserved service region at the top of the array holds the update routine. Byte program and page erase cannot touch it, and chip erase spares it. The array size is set by `ADDR_W` and the size of the service region by `ISP_BYTES`. The defaults model a 4 KB array with a 512-byte service region; a full-size instance uses 16 and 4096. Address bits above `ADDR_W` are dropped.

Top module: `isp_flash_ctrl`

## Requirements
- R1: After reset the register reads are: control (offset 0x00) = 0x02, meaning the enable is bit 2 = 0, output-memory enable bit 1 = 1 and bits 0 and 7 = 0; address high (0x01), address low (0x02), data (0x03) and command (0x04) all = 0x00. Busy is low. Every byte outside the service region reads 0xFF.
- R2: A command write (offset 0x04) with bit 7 = 1 starts the operation selected by bits 1..0 (00 program, 01 page erase, 10 chip erase, 11 protect) only when control bit 2 is 1. When bit 2 is 0, the command register and the array are unchanged and busy stays low.
- R3: Byte program stores old AND data at address {high,low}. Erased bytes read 0xFF.
- R4: Page erase sets to 0xFF the 512 bytes from {high & 0xFE, 0x00} through {high | 0x01, 0xFF}, whether the high byte is even or odd. All other bytes are unchanged.
- R5: Chip erase sets every byte outside the service region to 0xFF and clears protection. Service-region bytes keep their contents; at reset each holds (address[7:0] XOR 0xA5).
- R6: After chip protect, every read returns 0x00 until a chip erase completes.
- R7: Busy stays high for exactly 16 cycles for program, 64 for page erase, 256 for chip erase and 4 for protect. While busy, a command read returns bit 7 = 1, and command writes are ignored.
- R8: Program or page erase whose target lies in the service region (the top ISP_BYTES bytes) is rejected: busy stays low and the array is unchanged.
- R9: Register writes to offsets other than 0x00–0x04 change nothing, and reads of those offsets return 0x00. Bits 6..3 of the control register and bits 6..2 of the command register read 0.
- R10: The read port returns the addressed byte one clock after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| rd_addr_i | input | 16 | Flash read address |
| rd_data_o | output | 8 | Flash read data, one cycle later |

## Verification
Program is tried on a fresh byte and then again on the same byte with a value that shares only some bits. This separates AND-merge behaviour from plain overwrite. Page erase is issued with an odd high byte and an off-page low byte, with marker bytes placed just below, inside and just above the page. This shows both the alignment and the extent of the erased range. Chip erase runs after protect, checking that the service-region pattern survives and that reads recover. Starts issued while disabled, while busy and into the service region are each followed by register and array reads that show nothing moved.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_PAGE = 2'b01,
    OP_CHIP = 2'b10,
    OP_PROT = 2'b11
  } isp_op_e;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_AHI  = 8'h01;
  localparam logic [7:0] OFS_ALO  = 8'h02;
  localparam logic [7:0] OFS_DATA = 8'h03;
  localparam logic [7:0] OFS_CMD  = 8'h04;

  localparam int unsigned CTRL_EN_BIT  = 2;
  localparam int unsigned CMD_GO_BIT   = 7;
  localparam logic [7:0]  ISP_FILL_KEY = 8'hA5;
endpackage

// File: rtl/isp_regs.sv
module isp_regs
  import isp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  output logic [7:0] rdata_o,
  output logic       isp_en_o,
  output logic [7:0] addr_hi_o,
  output logic [7:0] addr_lo_o,
  output logic [7:0] data_o,
  output logic       start_req_o,
  output isp_op_e    start_op_o
);
  logic       wdr_q, en_q, ome_q, ale_q;
  logic [7:0] ahi_q, alo_q, dat_q;
  isp_op_e    op_q;
  logic       cmd_wr_ok;

  // command register only moves when the key is set and nothing runs
  assign cmd_wr_ok = we_i && (addr_i == OFS_CMD) && en_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wdr_q <= 1'b0;
      en_q  <= 1'b0;
      ome_q <= 1'b1;
      ale_q <= 1'b0;
      ahi_q <= '0;
      alo_q <= '0;
      dat_q <= '0;
      op_q  <= OP_PROG;
    end else if (we_i) begin
      unique case (addr_i)
        OFS_CTRL: begin
          wdr_q <= wdata_i[7];
          en_q  <= wdata_i[CTRL_EN_BIT];
          ome_q <= wdata_i[1];
          ale_q <= wdata_i[0];
        end
        OFS_AHI:  ahi_q <= wdata_i;
        OFS_ALO:  alo_q <= wdata_i;
        OFS_DATA: dat_q <= wdata_i;
        OFS_CMD:  if (cmd_wr_ok) op_q <= isp_op_e'(wdata_i[1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr_i)
      OFS_CTRL: rdata_o = {wdr_q, 4'b0, en_q, ome_q, ale_q};
      OFS_AHI:  rdata_o = ahi_q;
      OFS_ALO:  rdata_o = alo_q;
      OFS_DATA: rdata_o = dat_q;
      OFS_CMD:  rdata_o = {busy_i, 5'b0, op_q};
      default:  rdata_o = 8'h00;
    endcase
  end

  assign isp_en_o    = en_q;
  assign addr_hi_o   = ahi_q;
  assign addr_lo_o   = alo_q;
  assign data_o      = dat_q;
  assign start_req_o = cmd_wr_ok && wdata_i[CMD_GO_BIT];
  assign start_op_o  = isp_op_e'(wdata_i[1:0]);
endmodule

// File: rtl/isp_seq.sv
module isp_seq
  import isp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned LAT_PROG = 16,
  parameter int unsigned LAT_PAGE = 64,
  parameter int unsigned LAT_CHIP = 256,
  parameter int unsigned LAT_PROT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  isp_op_e           start_op_i,
  input  logic              in_isp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic              done_o,
  output isp_op_e           op_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic [7:0]        tgt_data_o
);
  localparam int unsigned LAT_MAX = (LAT_CHIP > LAT_PAGE) ? LAT_CHIP : LAT_PAGE;
  localparam int unsigned CNT_W   = $clog2(LAT_MAX + 1);

  logic [CNT_W-1:0] cnt_q, lat_sel;
  logic             accept;

  always_comb begin
    unique case (start_op_i)
      OP_PROG: lat_sel = CNT_W'(LAT_PROG - 1);
      OP_PAGE: lat_sel = CNT_W'(LAT_PAGE - 1);
      OP_CHIP: lat_sel = CNT_W'(LAT_CHIP - 1);
      default: lat_sel = CNT_W'(LAT_PROT - 1);
    endcase
  end

  // program/erase aimed at the service region never starts
  assign accept = start_req_i && !busy_o &&
                  !(in_isp_i && (start_op_i == OP_PROG || start_op_i == OP_PAGE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      cnt_q      <= '0;
      op_o       <= OP_PROG;
      tgt_addr_o <= '0;
      tgt_data_o <= '0;
    end else if (accept) begin
      busy_o     <= 1'b1;
      cnt_q      <= lat_sel;
      op_o       <= start_op_i;
      tgt_addr_o <= addr_i;
      tgt_data_o <= data_i;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = busy_o && (cnt_q == '0);
endmodule

// File: rtl/isp_array.sv
module isp_array
  import isp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAGE_W    = 9,
  parameter int unsigned ISP_BYTES = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  isp_op_e           op_i,
  input  logic [ADDR_W-1:0] tgt_addr_i,
  input  logic [7:0]        tgt_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              prot_o
);
  localparam int unsigned DEPTH    = 1 << ADDR_W;
  localparam int unsigned ISP_BASE = DEPTH - ISP_BYTES;
  localparam int unsigned PG_IDX_W = ADDR_W - PAGE_W;

  logic [7:0] mem_q [DEPTH];
  logic [PG_IDX_W-1:0] tgt_page;

  assign tgt_page = tgt_addr_i[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++)
        mem_q[i] <= (i >= ISP_BASE) ? (8'(i) ^ ISP_FILL_KEY) : 8'hFF;
    end else if (done_i) begin
      unique case (op_i)
        OP_PROG: mem_q[tgt_addr_i] <= mem_q[tgt_addr_i] & tgt_data_i;
        OP_PAGE: begin
          for (int i = 0; i < DEPTH; i++)
            if (PG_IDX_W'(i >> PAGE_W) == tgt_page) mem_q[i] <= 8'hFF;
        end
        OP_CHIP: begin
          for (int i = 0; i < ISP_BASE; i++) mem_q[i] <= 8'hFF;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          prot_o <= 1'b0;
    else if (done_i && op_i == OP_PROT)   prot_o <= 1'b1;
    else if (done_i && op_i == OP_CHIP)   prot_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= 8'h00;
    else         rd_data_o <= prot_o ? 8'h00 : mem_q[rd_addr_i];
  end
endmodule

// File: rtl/isp_flash_ctrl.sv
module isp_flash_ctrl
  import isp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned PAGE_W    = 9,
  parameter int unsigned ISP_BYTES = 512,
  parameter int unsigned LAT_PROG  = 16,
  parameter int unsigned LAT_PAGE  = 64,
  parameter int unsigned LAT_CHIP  = 256,
  parameter int unsigned LAT_PROT  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  output logic        busy_o,
  input  logic [15:0] rd_addr_i,
  output logic [7:0]  rd_data_o
);
  localparam int unsigned DEPTH    = 1 << ADDR_W;
  localparam int unsigned ISP_BASE = DEPTH - ISP_BYTES;

  logic              isp_en, start_req, done, prot;
  isp_op_e           start_op, cur_op;
  logic [7:0]        addr_hi, addr_lo, wr_data, tgt_data;
  logic [15:0]       full_addr;
  logic [ADDR_W-1:0] cur_addr, tgt_addr;
  logic              in_isp;

  assign full_addr = {addr_hi, addr_lo};
  assign cur_addr  = full_addr[ADDR_W-1:0];
  assign in_isp    = (32'(cur_addr) >= ISP_BASE);

  isp_regs u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .busy_i      (busy_o),
    .rdata_o     (reg_rdata_o),
    .isp_en_o    (isp_en),
    .addr_hi_o   (addr_hi),
    .addr_lo_o   (addr_lo),
    .data_o      (wr_data),
    .start_req_o (start_req),
    .start_op_o  (start_op)
  );

  isp_seq #(
    .ADDR_W(ADDR_W), .LAT_PROG(LAT_PROG), .LAT_PAGE(LAT_PAGE),
    .LAT_CHIP(LAT_CHIP), .LAT_PROT(LAT_PROT)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_req_i (start_req),
    .start_op_i  (start_op),
    .in_isp_i    (in_isp),
    .addr_i      (cur_addr),
    .data_i      (wr_data),
    .busy_o      (busy_o),
    .done_o      (done),
    .op_o        (cur_op),
    .tgt_addr_o  (tgt_addr),
    .tgt_data_o  (tgt_data)
  );

  isp_array #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ISP_BYTES(ISP_BYTES)
  ) u_array (
    .clk_i, .rst_ni,
    .done_i      (done),
    .op_i        (cur_op),
    .tgt_addr_i  (tgt_addr),
    .tgt_data_i  (tgt_data),
    .rd_addr_i   (rd_addr_i[ADDR_W-1:0]),
    .rd_data_o   (rd_data_o),
    .prot_o      (prot)
  );
endmodule

// File: rtl/isp_flash_ctrl_checker.sv
module isp_flash_ctrl_checker
  import isp_pkg::*;
#(
  parameter int unsigned LAT_PROG = 16,
  parameter int unsigned LAT_PAGE = 64,
  parameter int unsigned LAT_CHIP = 256,
  parameter int unsigned LAT_PROT = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       busy_o,
  input logic [7:0] rd_data_o,
  input logic       isp_en,
  input logic       in_isp,
  input logic       prot,
  input isp_op_e    cur_op
);
  logic        cmd_go;
  logic [15:0] run_len;

  assign cmd_go = reg_we_i && reg_addr_i == OFS_CMD && reg_wdata_i[CMD_GO_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_len <= '0;
    else if (busy_o) run_len <= run_len + 1'b1;
    else             run_len <= '0;
  end

  AST_NO_START_WHEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && !isp_en && !busy_o) |=> !busy_o); // R2

  AST_VALID_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && isp_en && !busy_o && !in_isp) |=> busy_o); // R7

  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_len == LAT_PROG || run_len == LAT_PAGE ||
                        run_len == LAT_CHIP || run_len == LAT_PROT)); // R7

  AST_OP_HELD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(cur_op)); // R7

  AST_ISP_REGION_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_go && !busy_o && in_isp && reg_wdata_i[1] == 1'b0) |=> !busy_o); // R8

  AST_PROT_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(prot) |-> rd_data_o == 8'h00); // R6
endmodule

bind isp_flash_ctrl isp_flash_ctrl_checker #(
  .LAT_PROG(LAT_PROG), .LAT_PAGE(LAT_PAGE), .LAT_CHIP(LAT_CHIP), .LAT_PROT(LAT_PROT)
) u_checker (
  .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
  .busy_o, .rd_data_o, .isp_en, .in_isp, .prot, .cur_op
);

// File: tb/isp_flash_ctrl_bench.sv
module isp_flash_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  ra = '0, wd = '0, rdv;
  logic        busy;
  logic [15:0] fa = '0;
  logic [7:0]  fd;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  isp_flash_ctrl u_isp_flash_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(ra),
    .reg_wdata_i(wd), .reg_rdata_o(rdv), .busy_o(busy),
    .rd_addr_i(fa), .rd_data_o(fd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; ra = a; wd = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rreg(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); ra = a; #1 v = rdv;
  endtask

  task automatic rflash(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); fa = a;
    @(negedge clk); @(negedge clk); v = fd;
  endtask

  // issue a command and return the number of cycles busy stayed high
  task automatic go(input logic [7:0] cmd, output int cyc);
    @(negedge clk); we = 1'b1; ra = 8'h04; wd = cmd;
    @(negedge clk); we = 1'b0;
    cyc = 0;
    while (busy) begin cyc++; @(negedge clk); end
  endtask

  task automatic set_addr(input logic [15:0] a);
    wr(8'h01, a[15:8]); wr(8'h02, a[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rreg(8'h00, v); chk("R1 ctrl", v, 8'h02);
    rreg(8'h04, v); chk("R1 cmd", v, 8'h00);
    rreg(8'h01, v); chk("R1 ahi", v, 8'h00);
    chk("R1 busy", busy, 0);
    rflash(16'h0123, v); chk("R1 erased", v, 8'hFF);
  endtask

  task automatic t_locked();
    logic [7:0] v; int c;
    set_addr(16'h0A05); wr(8'h03, 8'h00);
    go(8'h80, c); chk("R2 no busy", c, 0);
    rreg(8'h04, v); chk("R2 cmd kept", v, 8'h00);
    rflash(16'h0A05, v); chk("R2 array kept", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v; int c;
    wr(8'h00, 8'h06);
    rreg(8'h00, v); chk("R1 ctrl en", v, 8'h06);
    wr(8'h03, 8'h22); go(8'h80, c);
    chk("R7 prog cycles", c, 16);
    rflash(16'h0A05, v); chk("R3 first prog", v, 8'h22);
    rflash(16'h0A04, v); chk("R3 neighbour", v, 8'hFF);
    wr(8'h03, 8'h0F); go(8'h80, c);
    rflash(16'h0A05, v); chk("R3 and merge", v, 8'h02);
  endtask

  task automatic t_page();
    logic [7:0] v; int c;
    wr(8'h03, 8'h11);
    set_addr(16'h01FF); go(8'h80, c);
    set_addr(16'h0200); go(8'h80, c);
    set_addr(16'h03FF); go(8'h80, c);
    set_addr(16'h0400); go(8'h80, c);
    set_addr(16'h0377); go(8'h81, c);
    chk("R7 page cycles", c, 64);
    rflash(16'h0200, v); chk("R4 page start", v, 8'hFF);
    rflash(16'h03FF, v); chk("R4 page end", v, 8'hFF);
    rflash(16'h01FF, v); chk("R4 below kept", v, 8'h11);
    rflash(16'h0400, v); chk("R4 above kept", v, 8'h11);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v; int c;
    set_addr(16'h0600); wr(8'h03, 8'h00);
    @(negedge clk); we = 1'b1; ra = 8'h04; wd = 8'h80;
    @(negedge clk); ra = 8'h04; wd = 8'h82;
    @(negedge clk); we = 1'b0; #1;
    rreg(8'h04, v); chk("R7 cmd busy bit", v, 8'h80);
    c = 3;
    while (busy) begin c++; @(negedge clk); end
    chk("R7 not restarted", c, 17);
    rflash(16'h0600, v); chk("R7 prog landed", v, 8'h00);
    rflash(16'h0A05, v); chk("R7 no chip erase", v, 8'h02);
  endtask

  task automatic t_isp_reject();
    logic [7:0] v; int c;
    set_addr(16'h0E10); go(8'h80, c); chk("R8 prog rejected", c, 0);
    go(8'h81, c); chk("R8 page rejected", c, 0);
    rflash(16'h0E10, v); chk("R8 region kept", v, 8'hB5);
  endtask

  task automatic t_regmap();
    logic [7:0] v; int c;
    wr(8'h05, 8'h80); wr(8'h07, 8'hFF);
    chk("R9 no start", busy, 0);
    rreg(8'h07, v); chk("R9 unmapped read", v, 8'h00);
    rreg(8'h01, v); chk("R9 ahi kept", v, 8'h0E);
    wr(8'h00, 8'h7E);
    rreg(8'h00, v); chk("R9 ctrl spare bits", v, 8'h06);
    wr(8'h04, 8'h7C);
    rreg(8'h04, v); chk("R9 cmd spare bits", v, 8'h00);
  endtask

  task automatic t_protect_chip();
    logic [7:0] v; int c;
    go(8'h83, c); chk("R7 prot cycles", c, 4);
    rflash(16'h0E10, v); chk("R6 isp reads zero", v, 8'h00);
    rflash(16'h0A00, v); chk("R6 erased reads zero", v, 8'h00);
    go(8'h82, c); chk("R7 chip cycles", c, 256);
    rflash(16'h0A05, v); chk("R5 erased", v, 8'hFF);
    rflash(16'h0600, v); chk("R5 erased 2", v, 8'hFF);
    rflash(16'h0E10, v); chk("R5 region spared", v, 8'hB5);
    rflash(16'h0FFF, v); chk("R5 region top", v, 8'h5A);
  endtask

  task automatic t_read_lat();
    @(negedge clk); fa = 16'h0E01;
    @(negedge clk); chk("R10 one cycle", fd, 8'hA4);
    fa = 16'h0E02;
    @(negedge clk); chk("R10 next addr", fd, 8'hA7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_locked();
    t_program();
    t_page();
    t_busy_ignore();
    t_isp_reject();
    t_regmap();
    t_protect_chip();
    t_read_lat();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule